// File: doc/BRIEF.md
# Three-Phase Sine Duty Reference Generator

This block produces three duty-cycle words for a three-leg inverter modulator. The three words trace sine waves 120 degrees apart. A phase accumulator advances by a programmable frequency word once per PWM period. The accumulator picks an entry from a 64-point sine table. Each entry is centred at half scale and its swing is limited, so the commanded duty stays between 10% and 90% of the carrier count.

The frequency word is f_out x 64 x 256 / f_update. For example, a 50 Hz fundamental refreshed at 20 kHz needs a word of about 41.

An enable input can add a third-harmonic term of roughly 15% of the fundamental to every phase. That term is common to all three legs. It cancels between line-to-line voltages and flattens the peaks of each phase, so the usable output voltage rises for the same DC bus. The summed value is saturated to the duty band before it reaches the outputs.

Carrier generation, dead time and gate drive sit downstream and are not part of this block.

Top module: `dds3_sine_ref`

## Requirements
- R1: While `rst` is high and until the first accepted strobe after it, the accumulator is zero and every duty output equals 24750 (sample 55 x 450).
- R2: On each clock edge that samples `pwm_tick` high, the 14-bit accumulator adds `freq_word` modulo 2^14. Strobes on consecutive cycles each advance it once, and a cycle without the strobe leaves it unchanged.
- R3: Table index for leg A is accumulator bits [13:8]. For leg B it is bits [13:8] of (accumulator + 5461) mod 2^14. For leg C it is bits [13:8] of (accumulator + 10923) mod 2^14.
- R4: The sample for index i is s(i) = 55 + round(44 x sin(2*pi*i/64)), rounded half away from zero. The duty word is s(i) x 450, which spans 4950 to 44550: 10% to 90% of a 49500-count full scale.
- R5: The three legs trace the same waveform 120 degrees apart. With injection off, the three duties sum to within 3150 counts of 74250.
- R6: All three duty outputs change together, and only on the edge that samples `pwm_tick` high. They then show the advanced accumulator. Changes to `freq_word` or `harm_en` without a strobe leave the outputs unchanged.
- R7: With `harm_en` high at the strobe, each leg adds floor((s((3 x i) mod 64) - 55) x 5 / 32) to its sample before scaling, where i is that leg's own index.
- R8: The scaled result is saturated to the range 4950 to 44550, so no duty output ever leaves that band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_tick | input | 1 | One-cycle strobe at the start of each PWM period |
| freq_word | input | 14 | Phase increment added per strobe |
| harm_en | input | 1 | Adds the third-harmonic term when high |
| duty_a | output | 16 | Duty word, leg A (0 degrees) |
| duty_b | output | 16 | Duty word, leg B (120 degrees) |
| duty_c | output | 16 | Duty word, leg C (240 degrees) |

## Verification
The assertions assume that `rst` is held through at least one rising edge before use. They also assume that `pwm_tick`, `freq_word` and `harm_en` are synchronous to `clk`, because the step and hold properties compare values one edge apart.

The stimulus changes every input only on the falling edge, and it moves `freq_word` and `harm_en` while no strobe is pending. Each leg therefore sees one settled set of inputs at the edge that loads it. Strobes come as single pulses, and one deliberate burst on consecutive cycles exercises repeated advances.

// File: rtl/dds3_pkg.sv
package dds3_pkg;

  // Table geometry: 64 points per cycle, built from one quarter of 16 steps.
  localparam int TBL_IDX_W  = 6;
  localparam int QTR_STEPS  = 16;
  // Sample domain: centre and peak swing, in units of one duty step.
  localparam int SAMPLE_MID = 55;
  localparam int SAMPLE_AMP = 44;

  // Rounded SAMPLE_AMP * sin(k * 90deg / 16), k = 0..16.
  function automatic int qtr_sin(input int k);
    case (k)
      0:  return 0;
      1:  return 4;
      2:  return 9;
      3:  return 13;
      4:  return 17;
      5:  return 21;
      6:  return 24;
      7:  return 28;
      8:  return 31;
      9:  return 34;
      10: return 37;
      11: return 39;
      12: return 41;
      13: return 42;
      14: return 43;
      15: return 44;
      default: return SAMPLE_AMP;
    endcase
  endfunction

endpackage

// File: rtl/dds3_sine_lut.sv
module dds3_sine_lut
  import dds3_pkg::*;
(
  input  logic [TBL_IDX_W-1:0]  idx,
  output logic signed [7:0]     swing
);

  logic [3:0] k;
  int         mag;

  assign k = idx[3:0];

  // Quadrant symmetry folds the full cycle onto the quarter table.
  always_comb begin
    case (idx[5:4])
      2'd0:    mag =  qtr_sin(int'(k));
      2'd1:    mag =  qtr_sin(QTR_STEPS - int'(k));
      2'd2:    mag = -qtr_sin(int'(k));
      default: mag = -qtr_sin(QTR_STEPS - int'(k));
    endcase
    swing = 8'(mag);
  end

endmodule

// File: rtl/dds3_phase_acc.sv
module dds3_phase_acc #(
  parameter int ACC_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_next
);

  logic [ACC_W-1:0] acc_q;

  assign acc_next = acc_q + step;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (tick) acc_q <= acc_next;
  end

  // R2: one advance per accepted strobe, none otherwise
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> acc_q == $past(acc_q) + $past(step));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(acc_q));

endmodule

// File: rtl/dds3_leg.sv
module dds3_leg
  import dds3_pkg::*;
#(
  parameter int ACC_W      = 14,
  parameter int IDX_LSB    = 8,
  parameter int PH_OFF     = 0,
  parameter int DUTY_W     = 16,
  parameter int SCALE      = 450,
  parameter int HARM_NUM   = 5,
  parameter int HARM_SHIFT = 5,
  parameter int DUTY_LO    = 4950,
  parameter int DUTY_HI    = 44550
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              inj_en,
  input  logic [ACC_W-1:0]  acc_next,
  output logic [DUTY_W-1:0] duty_q
);

  localparam int DUTY_RST = SAMPLE_MID * SCALE;

  logic [ACC_W-1:0]        ph_sum;
  logic [TBL_IDX_W-1:0]    idx;
  logic [TBL_IDX_W-1:0]    h_idx;
  logic signed [7:0]       fund_sw;
  logic signed [7:0]       harm_sw;
  int                      harm_add;
  int                      sample;
  int                      raw;
  int                      clamped;

  assign ph_sum = acc_next + ACC_W'(PH_OFF);
  assign idx    = ph_sum[IDX_LSB +: TBL_IDX_W];
  // Three times the fundamental index, wrapping modulo the table length.
  assign h_idx  = idx + {idx[TBL_IDX_W-2:0], 1'b0};

  dds3_sine_lut u_fund (.idx(idx),   .swing(fund_sw));
  dds3_sine_lut u_harm (.idx(h_idx), .swing(harm_sw));

  always_comb begin
    harm_add = (int'(harm_sw) * HARM_NUM) >>> HARM_SHIFT;
    sample   = SAMPLE_MID + int'(fund_sw) + (inj_en ? harm_add : 0);
    raw      = sample * SCALE;
    if (raw < DUTY_LO)      clamped = DUTY_LO;
    else if (raw > DUTY_HI) clamped = DUTY_HI;
    else                    clamped = raw;
  end

  always_ff @(posedge clk) begin
    if (rst)       duty_q <= DUTY_W'(DUTY_RST);
    else if (tick) duty_q <= DUTY_W'(clamped);
  end

  // R8: registered duty never leaves the safe band
  p_band_r8: assert property (@(posedge clk) disable iff (rst)
    (duty_q >= DUTY_W'(DUTY_LO)) && (duty_q <= DUTY_W'(DUTY_HI)));

endmodule

// File: rtl/dds3_sine_ref.sv
module dds3_sine_ref
  import dds3_pkg::*;
#(
  parameter int IDX_LSB    = 8,
  parameter int DUTY_W     = 16,
  parameter int SCALE      = 450,
  parameter int HARM_NUM   = 5,
  parameter int HARM_SHIFT = 5,
  parameter int DUTY_LO    = 4950,
  parameter int DUTY_HI    = 44550
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pwm_tick,
  input  logic [IDX_LSB+TBL_IDX_W-1:0]  freq_word,
  input  logic                          harm_en,
  output logic [DUTY_W-1:0]             duty_a,
  output logic [DUTY_W-1:0]             duty_b,
  output logic [DUTY_W-1:0]             duty_c
);

  localparam int ACC_W    = IDX_LSB + TBL_IDX_W;
  localparam int N_LEGS   = 3;
  localparam int DUTY_RST = SAMPLE_MID * SCALE;

  logic [ACC_W-1:0]  acc_next;
  logic [DUTY_W-1:0] duty_arr [N_LEGS];

  dds3_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .tick     (pwm_tick),
    .step     (freq_word),
    .acc_next (acc_next)
  );

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    // Offset of g thirds of a cycle, rounded to the nearest count.
    localparam int OFF = (g * (2 ** ACC_W) + 1) / N_LEGS;
    dds3_leg #(
      .ACC_W      (ACC_W),
      .IDX_LSB    (IDX_LSB),
      .PH_OFF     (OFF),
      .DUTY_W     (DUTY_W),
      .SCALE      (SCALE),
      .HARM_NUM   (HARM_NUM),
      .HARM_SHIFT (HARM_SHIFT),
      .DUTY_LO    (DUTY_LO),
      .DUTY_HI    (DUTY_HI)
    ) u_leg (
      .clk      (clk),
      .rst      (rst),
      .tick     (pwm_tick),
      .inj_en   (harm_en),
      .acc_next (acc_next),
      .duty_q   (duty_arr[g])
    );
  end

  assign duty_a = duty_arr[0];
  assign duty_b = duty_arr[1];
  assign duty_c = duty_arr[2];

  // R6: outputs only move on an accepted strobe
  p_sync_r6: assert property (@(posedge clk) disable iff (rst)
    !pwm_tick |=> $stable(duty_a) && $stable(duty_b) && $stable(duty_c));
  // R1: first cycle out of reset shows the centre duty on all legs
  p_rst_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (duty_a == DUTY_W'(DUTY_RST)) && (duty_b == DUTY_W'(DUTY_RST))
                   && (duty_c == DUTY_W'(DUTY_RST)));

endmodule

// File: tb/tb_dds3_sine_ref.sv
module tb_dds3_sine_ref;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm_tick = 1'b0;
  logic [13:0] freq_word = '0;
  logic        harm_en = 1'b0;
  logic [15:0] duty_a, duty_b, duty_c;

  int checks = 0;
  int errors = 0;
  int bacc   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dds3_sine_ref dut (
    .clk(clk), .rst(rst), .pwm_tick(pwm_tick), .freq_word(freq_word),
    .harm_en(harm_en), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int samp(input int i);
    real x;
    x = 44.0 * $sin(2.0 * 3.14159265358979 * i / 64.0);
    if (x >= 0.0) return 55 + $rtoi(x + 0.5);
    else          return 55 - $rtoi(-x + 0.5);
  endfunction

  function automatic int exp_duty(input int acc, input int leg, input bit inj);
    int off, idx, s, d;
    off = (leg * 16384 + 1) / 3;
    idx = (((acc + off) % 16384) >> 8) & 63;
    s = samp(idx);
    if (inj) s = s + $rtoi($floor(real'((samp((3 * idx) % 64) - 55) * 5) / 32.0));
    d = s * 450;
    if (d < 4950)  d = 4950;
    if (d > 44550) d = 44550;
    return d;
  endfunction

  task automatic cmp_all(input string req);
    chk({req, " leg A"}, int'(duty_a), exp_duty(bacc, 0, harm_en));
    chk({req, " leg B"}, int'(duty_b), exp_duty(bacc, 1, harm_en));
    chk({req, " leg C"}, int'(duty_c), exp_duty(bacc, 2, harm_en));
  endtask

  task automatic step_one();
    @(negedge clk) pwm_tick = 1'b1;
    bacc = (bacc + int'(freq_word)) % 16384;
    @(negedge clk) pwm_tick = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; pwm_tick = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; pwm_tick = 1'b0; bacc = 0;
    @(negedge clk);
    chk("R1 reset A", int'(duty_a), 24750);
    chk("R1 reset B", int'(duty_b), 24750);
    chk("R1 reset C", int'(duty_c), 24750);
    // zero step keeps accumulator at zero: shows indices 0, 21, 42 (R3)
    freq_word = 14'd0;
    step_one();
    cmp_all("R1 R3 acc zero");
  endtask

  task automatic t_sweep();
    int mn = 99999, mx = 0, sum;
    freq_word = 14'd256; harm_en = 1'b0;
    for (int n = 0; n < 64; n++) begin
      step_one();
      cmp_all("R3 R4 sweep");
      if (int'(duty_a) < mn) mn = int'(duty_a);
      if (int'(duty_a) > mx) mx = int'(duty_a);
      sum = int'(duty_a) + int'(duty_b) + int'(duty_c);
      if (sum < 74250 - 3150 || sum > 74250 + 3150)
        chk("R5 balanced sum", sum, 74250);
      else checks++;
    end
    chk("R4 min duty 10%", mn, 4950);
    chk("R4 max duty 90%", mx, 44550);
  endtask

  task automatic t_hold();
    logic [15:0] a0, b0, c0;
    freq_word = 14'd1000; step_one();
    a0 = duty_a; b0 = duty_b; c0 = duty_c;
    repeat (10) @(negedge clk);
    freq_word = 14'd5000; harm_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 hold A", int'(duty_a), int'(a0));
    chk("R6 hold B", int'(duty_b), int'(b0));
    chk("R6 hold C", int'(duty_c), int'(c0));
    harm_en = 1'b0; freq_word = 14'd1000;
    step_one();
    cmp_all("R2 R6 resume");
  endtask

  task automatic t_fw41();
    freq_word = 14'd41;
    for (int n = 0; n < 400; n++) begin
      step_one();
      cmp_all("R2 fw 41");
    end
  endtask

  task automatic t_burst();
    freq_word = 14'd700;
    @(negedge clk) pwm_tick = 1'b1;
    repeat (3) @(negedge clk);
    pwm_tick = 1'b0;
    bacc = (bacc + 2100) % 16384;
    cmp_all("R2 burst");
    freq_word = 14'd16383;
    for (int n = 0; n < 12; n++) begin
      step_one();
      cmp_all("R2 wrap");
    end
  endtask

  task automatic t_inject();
    bit inband;
    freq_word = 14'd256; harm_en = 1'b1;
    for (int n = 0; n < 64; n++) begin
      step_one();
      cmp_all("R7 inject");
      inband = duty_a >= 16'd4950 && duty_a <= 16'd44550;
      chk("R8 band A", int'(inband), 1);
    end
    harm_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_fw41();
    t_burst();
    t_inject();
    t_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule